// File: doc/BRIEF.md
# Cipher Accelerator Reset and Interrupt Controller

This block sits beside a cipher engine and gives software three levels of reset, a status word and an interrupt path. Software writes request bits into a reset control word. The lightest level clears only the pending interrupt sources. The middle level restarts the engine's state and runs an initialisation routine, but leaves the interrupt mask alone. The full level returns everything, the mask included, to its power-on value and also runs the routine. While the routine runs, the block drives a clear-state line to the engine and ignores other traffic. A status word shows when the routine has finished.

The interrupt side keeps three sticky sources: engine done, engine error and address error. Address error is raised when software writes to the read-only status word. A mask word gates each source onto one interrupt line. All registers are word addressed, and `bus_rdata` follows `bus_addr` with no delay.

Top module: `acc_rst_ctl`

## Requirements
- R1: The reset control word is at address 0. Bit 0 requests a full reset, bit 1 a module initialisation and bit 2 an interrupt reset. All higher bits read zero and have no effect. The interrupt-reset bit reads 1 for one cycle after its write and then 0. The full-reset and initialisation bits read 1 while the routine runs and 0 once it ends.
- R2: An interrupt reset clears the interrupt status word and leaves the mask and the status word unchanged.
- R3: A full reset clears the interrupt status, sets the mask to 3'b111 and starts the initialisation routine.
- R4: A module initialisation does the same as a full reset, except that the mask keeps its value.
- R5: The initialisation routine lasts INIT_CYCLES clock edges (default 16). Status bit 0 (init done) at address 1 drops on the edge that accepts the request and rises on the 16th edge after it. `eng_clear` is high exactly while the routine runs.
- R6: When several request bits are written together, full reset wins over initialisation, and initialisation wins over interrupt reset. Only the winner's bit is held in the control word.
- R7: A write to address 1 leaves the status word unchanged and sets interrupt status bit 2 (address error).
- R8: Interrupt status is at address 2. Bit 0 is set by an `eng_done` pulse and bit 1 by an `eng_err` pulse. Status bits stay set until a reset request of any level clears them.
- R9: The mask is at address 3, with bits 2:0 where 1 means masked. `irq` is high when any status bit is set and its mask bit is 0.
- R10: While the routine runs, writes to addresses 1 to 3 and engine pulses have no effect. Writes to address 0 are still accepted.
- R11: Hardware reset leaves the mask at 3'b111, the interrupt status and the control word at 0, and init done at 0. The routine then runs once after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| eng_done | input | 1 | One-cycle done pulse from the engine |
| eng_err | input | 1 | One-cycle error pulse from the engine |
| eng_clear | output | 1 | High while the initialisation routine clears the engine |
| irq | output | 1 | Interrupt request |

## Verification
Every register update lands on the clock edge that accepts the write or pulse. The bench drives stimulus on a falling edge, lets exactly one rising edge pass, and reads the result on the next falling edge. The interrupt-reset bit is checked there and again one falling edge later, when it must read zero. For the routine, the bench counts falling edges from the accepting edge. It requires init done to be low after the 15th edge and high after the 16th. Writes issued during the routine are subtracted from that count, so the deadline is still sampled on the exact edge.

// File: rtl/acc_rst_pkg.sv
package acc_rst_pkg;
   localparam int unsigned NSRC     = 3;
   localparam int unsigned SRC_DONE = 0;
   localparam int unsigned SRC_ERR  = 1;
   localparam int unsigned SRC_ADDR = 2;
   localparam int unsigned RC_FULL  = 0;
   localparam int unsigned RC_MODI  = 1;
   localparam int unsigned RC_IRQR  = 2;
   localparam int unsigned RC_W     = 3;

   typedef enum logic [1:0] {
      SEL_RCTL  = 2'd0,
      SEL_STAT  = 2'd1,
      SEL_ISTAT = 2'd2,
      SEL_IMASK = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/acc_rst_seq.sv
module acc_rst_seq
   import acc_rst_pkg::*;
#(
   parameter int unsigned INIT_CYCLES = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_vld,
   input  logic [RC_W-1:0] req_bits,
   output logic            busy,
   output logic            init_done,
   output logic [RC_W-1:0] rctl_q,
   output logic            stat_clr,
   output logic            mask_rst
);
   localparam int unsigned CNT_W = (INIT_CYCLES > 2) ? $clog2(INIT_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

   logic             full_win, modi_win, irqr_win;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      full_win = req_vld & req_bits[RC_FULL];
      modi_win = req_vld & ~req_bits[RC_FULL] & req_bits[RC_MODI];
      irqr_win = req_vld & ~req_bits[RC_FULL] & ~req_bits[RC_MODI] & req_bits[RC_IRQR];
      stat_clr = full_win | modi_win | irqr_win;
      mask_rst = full_win;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b1;
         cnt_q     <= '0;
         init_done <= 1'b0;
         rctl_q    <= '0;
      end else if (full_win | modi_win) begin
         busy      <= 1'b1;
         cnt_q     <= '0;
         init_done <= 1'b0;
         rctl_q    <= '0;
         rctl_q[RC_FULL] <= full_win;
         rctl_q[RC_MODI] <= modi_win;
      end else begin
         rctl_q[RC_IRQR] <= irqr_win;
         if (busy) begin
            if (cnt_q == CNT_LAST) begin
               busy            <= 1'b0;
               init_done       <= 1'b1;
               rctl_q[RC_FULL] <= 1'b0;
               rctl_q[RC_MODI] <= 1'b0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/acc_irq_bank.sv
module acc_irq_bank
   import acc_rst_pkg::*;
#(
   parameter int unsigned N = NSRC
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         mask_rst,
   input  logic [N-1:0] ev,
   input  logic         mask_we,
   input  logic [N-1:0] mask_wd,
   output logic [N-1:0] istat,
   output logic [N-1:0] imask,
   output logic         irq
);
   for (genvar g = 0; g < N; g++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     istat[g] <= 1'b0;
         else if (clr)   istat[g] <= 1'b0;
         else if (ev[g]) istat[g] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        imask <= '1;
      else if (mask_rst) imask <= '1;
      else if (mask_we)  imask <= mask_wd;
   end

   assign irq = |(istat & ~imask);
endmodule

// File: rtl/acc_rd_mux.sv
module acc_rd_mux
   import acc_rst_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              hit,
   input  reg_sel_e          sel,
   input  logic [RC_W-1:0]   rctl,
   input  logic              init_done,
   input  logic [NSRC-1:0]   istat,
   input  logic [NSRC-1:0]   imask,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (hit) begin
         unique case (sel)
            SEL_RCTL:  rdata[RC_W-1:0] = rctl;
            SEL_STAT:  rdata[0]        = init_done;
            SEL_ISTAT: rdata[NSRC-1:0] = istat;
            SEL_IMASK: rdata[NSRC-1:0] = imask;
            default:   rdata           = '0;
         endcase
      end
   end
endmodule

// File: rtl/acc_rst_ctl.sv
module acc_rst_ctl
   import acc_rst_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned INIT_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              eng_done,
   input  logic              eng_err,
   output logic              eng_clear,
   output logic              irq
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if (DATA_W < NSRC) begin : g_bad_data
      $error("DATA_W must hold every interrupt source");
   end
   if (INIT_CYCLES < 2) begin : g_bad_init
      $error("INIT_CYCLES must be at least 2");
   end

   logic            addr_hit;
   reg_sel_e        sel;
   logic            busy, init_done, stat_clr, mask_rst;
   logic [RC_W-1:0] rctl_q;
   logic [NSRC-1:0] istat_q, imask_q, ev;
   logic            wr_rctl, wr_stat, wr_mask;
   logic            unused_wdata;

   if (ADDR_W > 2) begin : g_hi_dec
      assign addr_hit = (bus_addr[ADDR_W-1:2] == '0);
   end else begin : g_no_hi
      assign addr_hit = 1'b1;
   end

   assign sel          = reg_sel_e'(bus_addr[1:0]);
   assign unused_wdata = ^bus_wdata;

   always_comb begin
      wr_rctl = bus_wr & addr_hit & (sel == SEL_RCTL);
      wr_stat = bus_wr & addr_hit & (sel == SEL_STAT)  & ~busy;
      wr_mask = bus_wr & addr_hit & (sel == SEL_IMASK) & ~busy;
      ev           = '0;
      ev[SRC_DONE] = eng_done & ~busy;
      ev[SRC_ERR]  = eng_err  & ~busy;
      ev[SRC_ADDR] = wr_stat;
   end

   acc_rst_seq #(.INIT_CYCLES(INIT_CYCLES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_vld   (wr_rctl),
      .req_bits  (bus_wdata[RC_W-1:0]),
      .busy      (busy),
      .init_done (init_done),
      .rctl_q    (rctl_q),
      .stat_clr  (stat_clr),
      .mask_rst  (mask_rst)
   );

   acc_irq_bank #(.N(NSRC)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (stat_clr),
      .mask_rst (mask_rst),
      .ev       (ev),
      .mask_we  (wr_mask),
      .mask_wd  (bus_wdata[NSRC-1:0]),
      .istat    (istat_q),
      .imask    (imask_q),
      .irq      (irq)
   );

   acc_rd_mux #(.DATA_W(DATA_W)) u_rd (
      .hit       (addr_hit),
      .sel       (sel),
      .rctl      (rctl_q),
      .init_done (init_done),
      .istat     (istat_q),
      .imask     (imask_q),
      .rdata     (bus_rdata)
   );

   assign eng_clear = busy;
endmodule

// File: rtl/acc_rst_ctl_chk.sv
module acc_rst_ctl_chk
   import acc_rst_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              eng_clear,
   input logic              init_done,
   input logic [RC_W-1:0]   rctl_q,
   input logic [NSRC-1:0]   istat_q,
   input logic [NSRC-1:0]   imask_q
);
   logic            wr_rc, wr_st;
   logic [RC_W-1:0] wb;
   logic            unused_chk;

   assign wr_rc      = bus_wr && (bus_addr == ADDR_W'(0));
   assign wr_st      = bus_wr && (bus_addr == ADDR_W'(1));
   assign wb         = bus_wdata[RC_W-1:0];
   assign unused_chk = ^bus_wdata;

   a_r1_irqr_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      rctl_q[RC_IRQR] && !(wr_rc && wb[RC_IRQR]) |=> !rctl_q[RC_IRQR]);

   a_r2_irqr_scope: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rc && wb == 3'b100 && !eng_clear |=>
         istat_q == '0 && imask_q == $past(imask_q) && init_done == $past(init_done));

   a_r3_full_reset: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rc && wb[RC_FULL] |=> imask_q == '1 && istat_q == '0 && !init_done && eng_clear);

   a_r4_modi_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rc && !wb[RC_FULL] && wb[RC_MODI] |=>
         imask_q == $past(imask_q) && istat_q == '0 && !init_done);

   a_r5_done_after_routine: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> $past(eng_clear));

   a_r5_not_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_clear |-> !init_done);

   a_r7_addr_err: assert property (@(posedge clk) disable iff (!rst_n)
      wr_st && !eng_clear |=> istat_q[SRC_ADDR]);

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_rc && |wb) |=> (istat_q & $past(istat_q)) == $past(istat_q));

   a_r10_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      eng_clear && !wr_rc |=> imask_q == $past(imask_q));
endmodule

bind acc_rst_ctl acc_rst_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .eng_clear (eng_clear),
   .init_done (init_done),
   .rctl_q    (rctl_q),
   .istat_q   (istat_q),
   .imask_q   (imask_q)
);

// File: tb/acc_rst_ctl_tb.sv
module acc_rst_ctl_tb;
   localparam int unsigned ADDR_W = 4;
   localparam int unsigned DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              eng_done = 1'b0;
   logic              eng_err = 1'b0;
   logic              eng_clear;
   logic              irq;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   acc_rst_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_CYCLES(16)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .eng_done  (eng_done),
      .eng_err   (eng_err),
      .eng_clear (eng_clear),
      .irq       (irq)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      bus_addr = ADDR_W'(a);
      #1;
      v = bus_rdata;
   endtask

   task automatic chk_reg(input string req, input string what, input int a,
                          input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, what, v, exp);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      bus_addr  = ADDR_W'(a);
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic pulse(input bit d, input bit e);
      eng_done = d;
      eng_err  = e;
      @(posedge clk);
      @(negedge clk);
      eng_done = 1'b0;
      eng_err  = 1'b0;
   endtask

   task automatic wait_routine(input string req, input int used);
      repeat (15 - used) @(negedge clk);
      chk_reg(req, "init done before 16th edge", 1, 32'h0);
      chk(req, "eng_clear before 16th edge", 32'(eng_clear), 32'h1);
      @(negedge clk);
      chk_reg(req, "init done at 16th edge", 1, 32'h1);
      chk(req, "eng_clear after routine", 32'(eng_clear), 32'h0);
      chk_reg("R1", "control word cleared after routine", 0, 32'h0);
   endtask

   task automatic t_hw_reset;
      repeat (3) @(negedge clk);
      chk_reg("R11", "mask after hw reset", 3, 32'h7);
      chk_reg("R11", "istat after hw reset", 2, 32'h0);
      chk_reg("R11", "control after hw reset", 0, 32'h0);
      chk_reg("R11", "init done in hw reset", 1, 32'h0);
      chk("R11", "irq in hw reset", 32'(irq), 32'h0);
      rst_n = 1'b1;
      wait_routine("R11", 0);
   endtask

   task automatic t_events;
      pulse(1'b1, 1'b0);
      chk_reg("R8", "done source", 2, 32'h1);
      chk("R9", "irq masked", 32'(irq), 32'h0);
      wr(3, 32'h6);
      chk("R9", "irq after unmask done", 32'(irq), 32'h1);
      pulse(1'b0, 1'b1);
      chk_reg("R8", "error source", 2, 32'h3);
      wr(3, 32'h7);
      chk("R9", "irq fully masked", 32'(irq), 32'h0);
      repeat (3) @(negedge clk);
      chk_reg("R8", "sources sticky", 2, 32'h3);
      wr(0, 32'hFFFF_FFF8);
      chk_reg("R1", "reserved bits read zero", 0, 32'h0);
      chk_reg("R1", "reserved write no clear", 2, 32'h3);
      chk_reg("R1", "reserved write keeps done", 1, 32'h1);
   endtask

   task automatic t_irq_reset;
      wr(3, 32'h5);
      chk("R9", "irq from error source", 32'(irq), 32'h1);
      wr(0, 32'h4);
      chk_reg("R1", "irq reset bit visible", 0, 32'h4);
      chk_reg("R2", "istat cleared", 2, 32'h0);
      chk_reg("R2", "mask kept", 3, 32'h5);
      chk_reg("R2", "init done kept", 1, 32'h1);
      chk("R2", "irq dropped", 32'(irq), 32'h0);
      chk("R2", "no routine", 32'(eng_clear), 32'h0);
      @(negedge clk);
      chk_reg("R1", "irq reset bit self-clears", 0, 32'h0);
   endtask

   task automatic t_modi;
      wr(3, 32'h2);
      pulse(1'b1, 1'b0);
      chk("R9", "irq before init", 32'(irq), 32'h1);
      wr(0, 32'h2);
      chk_reg("R1", "init bit held", 0, 32'h2);
      chk_reg("R4", "istat cleared", 2, 32'h0);
      chk_reg("R4", "mask preserved", 3, 32'h2);
      chk_reg("R5", "init done dropped", 1, 32'h0);
      wait_routine("R5", 0);
      chk_reg("R4", "mask preserved after routine", 3, 32'h2);
   endtask

   task automatic t_full;
      pulse(1'b0, 1'b1);
      chk_reg("R8", "error before full reset", 2, 32'h2);
      wr(0, 32'h1);
      chk_reg("R1", "full bit held", 0, 32'h1);
      chk_reg("R3", "mask restored", 3, 32'h7);
      chk_reg("R3", "istat cleared", 2, 32'h0);
      chk_reg("R3", "init done dropped", 1, 32'h0);
      chk("R3", "irq low", 32'(irq), 32'h0);
      wait_routine("R3", 0);
   endtask

   task automatic t_busy_ignore;
      wr(0, 32'h1);
      wr(3, 32'h0);
      wr(1, 32'h0);
      pulse(1'b1, 1'b0);
      pulse(1'b0, 1'b1);
      chk_reg("R10", "mask write ignored", 3, 32'h7);
      chk_reg("R10", "pulses and status write ignored", 2, 32'h0);
      wait_routine("R10", 4);
   endtask

   task automatic t_priority;
      wr(3, 32'h0);
      pulse(1'b1, 1'b0);
      wr(0, 32'h7);
      chk_reg("R6", "full wins over all", 0, 32'h1);
      chk_reg("R6", "mask restored by full", 3, 32'h7);
      wait_routine("R6", 0);
      wr(3, 32'h3);
      pulse(1'b0, 1'b1);
      wr(0, 32'h6);
      chk_reg("R6", "init wins over irq reset", 0, 32'h2);
      chk_reg("R6", "mask kept by init", 3, 32'h3);
      chk_reg("R6", "istat cleared", 2, 32'h0);
      wait_routine("R6", 0);
   endtask

   task automatic t_addr_err;
      chk("R7", "irq idle", 32'(irq), 32'h0);
      wr(1, 32'h0);
      chk_reg("R7", "status unchanged", 1, 32'h1);
      chk_reg("R7", "address error raised", 2, 32'h4);
      chk("R7", "irq from address error", 32'(irq), 32'h1);
      wr(1, 32'hFFFF_FFFF);
      chk_reg("R7", "status unchanged by ones", 1, 32'h1);
   endtask

   task automatic finish_run;
      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      t_hw_reset();
      t_events();
      t_irq_reset();
      t_modi();
      t_full();
      t_busy_ignore();
      t_priority();
      t_addr_err();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule